// File: doc/BRIEF.md
# Sigma-Delta Conversion Mode Sequencer

This block models the conversion control of a slow sigma-delta converter. An 8-bit mode register holds a 2-bit operating mode and a coding select bit. The sequencer supports three operating modes. Continuous mode converts without stopping. Single mode wakes, converts once and powers back down. Power-down mode does no conversions. Conversion timing comes from a parameterised period counter. A synthetic sample source stands in for the modulator and filter. Each finished conversion is encoded as unipolar or bipolar and written into a data register.

A host reads the data register through `data_out`. It holds `rd_active` high while a read is in progress and pulses `rd_done` when the read is finished. The `ready` flag has three rules. It drops one clock before every data update, so that a host does not start a read across the update. It rises together with the new data. It is cleared by a finished read or by any write to the mode register. A conversion that completes while a read is in progress is discarded.

Top module: `sdc_conv_seq`

## Requirements
- R1: After reset the block is in the following state: `mode_rdata` = 0x02, `data_out` = 0, `ready` = 0, `result_valid` = 0 and `conv_active` = 1, because the reset mode is continuous.
- R2: `mode_rdata` is {mode[1:0], 3'b000, uni, 1'b1, 1'b0}. Mode and uni are taken from write bits 7:6 and bit 2, and the other written bits have no effect.
- R3: Mode value 00 is continuous. The first result lands 2*PERIOD clock edges after reset release or after the mode write edge. Each later result lands PERIOD edges after the previous one.
- R4: Mode value 10 is single. The result lands PWRUP+2*PERIOD edges after the write edge. `conv_active` falls on that same edge, no further results follow, and `ready` and `data_out` hold their values.
- R5: Mode 11 (power-down) and mode 01 (reserved) run no conversions. In both, `conv_active` = 0 and `data_out` is unchanged.
- R6: A mode write clears `ready` on its edge. It abandons any conversion in flight, and the timing restarts from that edge.
- R7: `ready` falls on the edge one clock before a data update. It rises on the update edge, and `result_valid` pulses for exactly that one cycle.
- R8: A `rd_done` pulse clears `ready` on the next edge and leaves `data_out` unchanged.
- R9: A conversion that completes while `rd_active` is high is dropped. There is no update and no `result_valid`, `ready` stays 0, and the sample is still consumed.
- R10: The synthetic sample index k starts at 0 and counts every completed conversion. The sample is chosen by k mod 4: 0 gives -2^(DW-1), 1 gives 0, 2 gives 2^(DW-1)-1, and 3 gives (k*STEP) mod 2^DW.
- R11: With uni = 0 (bipolar), the code is the sample with its MSB inverted. Negative full scale gives all zeros, zero gives 100…0, and positive full scale gives all ones.
- R12: With uni = 1 (unipolar), a negative sample gives 0. Otherwise the code is {s[DW-2:0], s[DW-2]}, so zero gives all zeros and positive full scale gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| rd_active | input | 1 | Host read of the data register in progress |
| rd_done | input | 1 | Pulse: host read finished |
| mode_rdata | output | 8 | Mode register read value |
| data_out | output | DW | Data register |
| ready | output | 1 | New, unread result available |
| result_valid | output | 1 | One-cycle pulse on each data update |
| conv_active | output | 1 | Sequencer is powered (not in power-down) |

## Verification
The embedded properties check several local rules on every cycle:
- `ready` can rise only together with `result_valid`.
- The pre-update clock always leaves `ready` low.
- A mode write always clears `ready`.
- A completion that overlaps a read never changes `data_out`.
- A powered-down sequencer stays idle with stable data.

Some behaviour is only visible across a whole scenario in the bench:
- The exact landing edges of results after reset, after a restart and after a single wake-up.
- The order of the synthetic samples, including those consumed by dropped conversions.
- The codes produced in each coding mode.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_WAKE, ST_SETTLE, ST_RUN} seq_st_e;

  localparam logic [1:0] MD_CONT   = 2'b00;
  localparam logic [1:0] MD_RSVD   = 2'b01;
  localparam logic [1:0] MD_SINGLE = 2'b10;
  localparam logic [1:0] MD_PDOWN  = 2'b11;
endpackage

// File: rtl/sdc_timer.sv
`timescale 1ns/1ps
module sdc_timer #(
  parameter int CW     = 8,
  parameter int RST_LD = 1,
  parameter int MAX_LD = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          at_zero,
  output logic          at_one
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= CW'(RST_LD);
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign at_zero = run && (cnt_q == '0);
  assign at_one  = run && (cnt_q == CW'(1));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_LD));
endmodule

// File: rtl/sdc_sample_src.sv
`timescale 1ns/1ps
module sdc_sample_src #(
  parameter int DW   = 24,
  parameter int STEP = 291
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [DW-1:0] sample
);
  localparam logic [DW-1:0] STEP_V  = DW'(STEP);
  localparam logic [DW-1:0] NEG_FS  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] POS_FS  = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] idx_q;
  logic [DW-1:0] ramp;

  always_ff @(posedge clk) begin
    if (!rst_n)        idx_q <= '0;
    else if (advance)  idx_q <= idx_q + 1'b1;
  end

  assign ramp = idx_q * STEP_V;

  always_comb begin
    unique case (idx_q[1:0])
      2'd0:    sample = NEG_FS;
      2'd1:    sample = '0;
      2'd2:    sample = POS_FS;
      default: sample = ramp;
    endcase
  end
endmodule

// File: rtl/sdc_coder.sv
`timescale 1ns/1ps
module sdc_coder #(
  parameter int DW = 24
) (
  input  logic [DW-1:0] sample,
  input  logic          uni,
  output logic [DW-1:0] code
);
  function automatic logic [DW-1:0] encode(input logic [DW-1:0] s, input logic u);
    if (u) encode = s[DW-1] ? '0 : {s[DW-2:0], s[DW-2]};
    else   encode = {~s[DW-1], s[DW-2:0]};
  endfunction

  assign code = encode(sample, uni);
endmodule

// File: rtl/sdc_conv_seq.sv
`timescale 1ns/1ps
module sdc_conv_seq #(
  parameter int DW     = 24,
  parameter int PERIOD = 16,
  parameter int PWRUP  = 40,
  parameter int STEP   = 291
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [7:0]    mode_wdata,
  input  logic          rd_active,
  input  logic          rd_done,
  output logic [7:0]    mode_rdata,
  output logic [DW-1:0] data_out,
  output logic          ready,
  output logic          result_valid,
  output logic          conv_active
);
  import sdc_pkg::*;

  localparam int LD_SETTLE = 2*PERIOD - 1;
  localparam int LD_RUN    = PERIOD - 1;
  localparam int LD_WAKE   = PWRUP - 1;
  localparam int LD_MAX    = (LD_SETTLE > LD_WAKE) ? LD_SETTLE : LD_WAKE;
  localparam int CW        = $clog2(LD_MAX + 1) + 1;

  logic [1:0]    md_q;
  logic          uni_q;
  seq_st_e       st_q;
  logic          tmr_zero, tmr_one;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          converting;
  logic          conv_done, wake_done, pre_done;
  logic          commit, store;
  logic [DW-1:0] sample, code;
  logic [DW-1:0] data_q;
  logic          ready_q, valid_q;
  logic          unused_wbits;

  assign unused_wbits = ^{mode_wdata[5:3], mode_wdata[1:0]};

  // Internal events brought out for the checks below.
  assign converting = (st_q == ST_SETTLE) || (st_q == ST_RUN);
  assign conv_done  = tmr_zero && converting;
  assign wake_done  = tmr_zero && (st_q == ST_WAKE);
  assign pre_done   = tmr_one && converting;
  assign commit     = conv_done && !mode_wr;
  assign store      = commit && !rd_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      md_q  <= MD_CONT;
      uni_q <= 1'b0;
    end else if (mode_wr) begin
      md_q  <= mode_wdata[7:6];
      uni_q <= mode_wdata[2];
    end
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = CW'(LD_SETTLE);
    if (mode_wr) begin
      tmr_load = 1'b1;
      tmr_val  = (mode_wdata[7:6] == MD_SINGLE) ? CW'(LD_WAKE) : CW'(LD_SETTLE);
    end else if (wake_done) begin
      tmr_load = 1'b1;
    end else if (conv_done) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(LD_RUN);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_SETTLE;
    else if (mode_wr) begin
      unique case (mode_wdata[7:6])
        MD_CONT:   st_q <= ST_SETTLE;
        MD_SINGLE: st_q <= ST_WAKE;
        default:   st_q <= ST_OFF;
      endcase
    end
    else if (wake_done) st_q <= ST_SETTLE;
    else if (conv_done) st_q <= (md_q == MD_CONT) ? ST_RUN : ST_OFF;
  end

  sdc_timer #(.CW(CW), .RST_LD(LD_SETTLE), .MAX_LD(LD_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .run(st_q != ST_OFF), .at_zero(tmr_zero), .at_one(tmr_one)
  );

  sdc_sample_src #(.DW(DW), .STEP(STEP)) u_src (
    .clk(clk), .rst_n(rst_n), .advance(commit), .sample(sample)
  );

  sdc_coder #(.DW(DW)) u_coder (
    .sample(sample), .uni(uni_q), .code(code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      valid_q <= store;
      if (store) data_q <= code;
      if (mode_wr)                  ready_q <= 1'b0;
      else if (store)               ready_q <= 1'b1;
      else if (pre_done || rd_done) ready_q <= 1'b0;
    end
  end

  assign mode_rdata   = {md_q, 3'b000, uni_q, 2'b10};
  assign data_out     = data_q;
  assign ready        = ready_q;
  assign result_valid = valid_q;
  assign conv_active  = (st_q != ST_OFF);

  p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> result_valid);
  p_prefall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_done |=> !ready);
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!ready && !result_valid));
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && rd_active) |=> (!result_valid && $stable(data_out)));
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_active && !mode_wr) |=> (!conv_active && $stable(data_out)));
  p_rddone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !conv_done && !mode_wr) |=> (!ready && $stable(data_out)));
endmodule

// File: tb/sdc_conv_seq_tb.sv
`timescale 1ns/1ps
module sdc_conv_seq_tb;
  localparam int DW = 16;
  localparam int P  = 8;
  localparam int W  = 12;
  localparam int ST = 291;

  typedef struct {
    int          cyc;
    logic [15:0] data;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [7:0] mode_wdata = 8'h00;
  logic rd_active = 1'b0;
  logic rd_done = 1'b0;
  logic [7:0] mode_rdata;
  logic [DW-1:0] data_out;
  logic ready, result_valid, conv_active;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdc_conv_seq #(.DW(DW), .PERIOD(P), .PWRUP(W), .STEP(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .rd_active(rd_active), .rd_done(rd_done), .mode_rdata(mode_rdata),
    .data_out(data_out), .ready(ready), .result_valid(result_valid),
    .conv_active(conv_active)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R10 sample order, R11 bipolar and R12 unipolar coding, restated.
  function automatic logic [15:0] model(input int k, input bit uni);
    logic [15:0] s;
    case (k % 4)
      0:       s = 16'h8000;
      1:       s = 16'h0000;
      2:       s = 16'h7FFF;
      default: s = 16'(k * ST);
    endcase
    if (!uni) return s ^ 16'h8000;
    if (s[15]) return 16'h0000;
    return {s[14:0], s[14]};
  endfunction

  task automatic push(input int c, input int k, input bit uni, input string tag);
    exp_t e;
    e.cyc = c; e.data = model(k, uni); e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: pops the scoreboard whenever the design reports a result.
  always @(negedge clk) begin
    if (rst_n && result_valid && !done) begin
      if (sb.size() == 0) chk(1'b0, "R5/R9 unexpected result", data_out, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(data_out == e.data, {e.tag, " data"}, data_out, e.data);
        chk(cyc == e.cyc, {e.tag, " timing R3"}, cyc, e.cyc);
        chk(ready == 1'b1, "R7 ready with update", ready, 1);
      end
    end
  end

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic write_mode(input logic [7:0] v, output int e);
    mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_wr = 1'b0;
    e = cyc;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e, e2, e3, e4, e5, e6, e7;
    repeat (4) @(negedge clk);
    chk(mode_rdata == 8'h02, "R1 mode reset", mode_rdata, 8'h02);
    chk(data_out == 0, "R1 data reset", data_out, 0);
    chk(ready == 0 && result_valid == 0, "R1 flags reset", {ready, result_valid}, 0);
    chk(conv_active == 1, "R1 active reset", conv_active, 1);
    rst_n = 1'b1;
    e = cyc;
    push(e+16, 0, 0, "R3 R10 R11 k0");
    push(e+24, 1, 0, "R3 R11 k1");
    push(e+32, 2, 0, "R3 R11 k2");
    push(e+40, 3, 0, "R3 R10 k3");
    push(e+56, 5, 0, "R9 R10 k5");
    wait_to(e+22); chk(ready == 1, "R7 ready held", ready, 1);
    wait_to(e+23); chk(ready == 0, "R7 prefall", ready, 0);
    wait_to(e+33); rd_done = 1'b1;
    wait_to(e+34); rd_done = 1'b0;
    chk(ready == 0, "R8 read clears ready", ready, 0);
    chk(data_out == model(2, 0), "R8 data kept", data_out, model(2, 0));
    wait_to(e+45); rd_active = 1'b1;
    wait_to(e+49);
    chk(ready == 0, "R9 ready low after drop", ready, 0);
    chk(data_out == model(3, 0), "R9 data kept", data_out, model(3, 0));
    wait_to(e+50); rd_active = 1'b0;
    wait_to(e+58);

    write_mode(8'h06, e2);
    chk(ready == 0, "R6 write clears ready", ready, 0);
    chk(mode_rdata == 8'h06, "R2 readback", mode_rdata, 8'h06);
    push(e2+16, 6, 1, "R12 k6");
    push(e2+24, 7, 1, "R12 k7");
    push(e2+32, 8, 1, "R12 k8");
    push(e2+40, 9, 1, "R12 k9");
    wait_to(e2+42);

    write_mode(8'hFF, e3);
    chk(mode_rdata == 8'hC6, "R2 fixed bits", mode_rdata, 8'hC6);
    chk(conv_active == 0, "R5 power-down", conv_active, 0);
    wait_to(e3+60);
    chk(data_out == model(9, 1), "R5 data kept", data_out, model(9, 1));

    write_mode(8'h7F, e4);
    chk(mode_rdata == 8'h46, "R2 reserved readback", mode_rdata, 8'h46);
    wait_to(e4+60);
    chk(conv_active == 0, "R5 reserved idle", conv_active, 0);
    chk(data_out == model(9, 1), "R5 reserved data kept", data_out, model(9, 1));

    write_mode(8'h80, e5);
    chk(mode_rdata == 8'h82, "R2 single readback", mode_rdata, 8'h82);
    push(e5+28, 10, 0, "R4 k10");
    wait_to(e5+27); chk(conv_active == 1, "R4 still active", conv_active, 1);
    wait_to(e5+28); chk(conv_active == 0, "R4 back to idle", conv_active, 0);
    wait_to(e5+90);
    chk(ready == 1, "R4 ready held", ready, 1);
    chk(data_out == model(10, 0), "R4 data held", data_out, model(10, 0));
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    chk(ready == 0, "R8 single read", ready, 0);
    chk(data_out == model(10, 0), "R8 single data kept", data_out, model(10, 0));

    write_mode(8'h00, e6);
    wait_to(e6+10);
    write_mode(8'h00, e7);
    push(e7+16, 11, 0, "R6 restart k11");
    wait_to(e7+18);
    write_mode(8'hC0, e);
    wait_to(e+30);
    chk(sb.size() == 0, "R6 all expected results seen", sb.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule